// File: doc/BRIEF.md
# Revision-Selectable Control Register with APB Access

This block is an APB slave that holds a single 32-bit control word at offset 0x00. A compile-time switch picks one of two layouts. The base layout has a run enable and a three-bit mode. The extended layout adds a one-bit feature enable in a position that the base layout leaves unused.

Every bit that the chosen layout does not define is a constant. A per-bit parameter sets whether that constant is 0 or 1. No flop stands behind these bits, so bus writes cannot change what they return. The defined fields drive output ports for the logic they control. Software reaches the word through ordinary APB reads and writes, and is expected to read, change and write back, so that unknown bits are preserved.

When the feature bit is absent, the feature output is held at the legacy setting (on). When the bit is present, it resets to that same setting. Old software that never writes the bit therefore sees no change in behaviour.

Top module: `ctl_reg_apb`

## Requirements
- R1: Bit 0 is the run enable. It is read-write, resets to 0 and drives `ctl_en`.
- R2: Bits [3:1] are the mode. They are read-write, reset to 0 and drive `ctl_mode`.
- R3: With `REV_B`=0, bits [31:4] are undefined and `ctl_feat` is held at 1.
- R4: With `REV_B`=1, bit 4 is the feature enable. It is read-write, resets to 1 and drives `ctl_feat`. Bits [31:5] stay undefined.
- R5: An undefined bit i always reads `RSVD_ONES[i]`, whatever has been written. With the default `RSVD_ONES`=32'h8000_0000, bit 31 reads 1 and every other undefined bit reads 0.
- R6: The word changes only on a write access phase to offset 0x00, that is with `psel`, `penable` and `pwrite` all high. A setup phase alone, or a write to any other offset, leaves the word unchanged.
- R7: A read of any offset other than 0x00 returns 0.
- R8: `pready` is always 1 and `pslverr` is always 0.
- R9: The enable and mode fields sit at the same bit positions in both layouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| ctl_en | output | 1 | Run enable field |
| ctl_mode | output | 3 | Mode field |
| ctl_feat | output | 1 | Feature enable; constant 1 in the base layout |

## Verification
The assertions check the following on every cycle:
- Undefined bits of a register read carry exactly the configured constants.
- A write leaves only the defined bits of the word altered.
- Fields hold steady whenever no qualifying write occurs.
- Other offsets read zero.
- The handshake outputs never change.

Only the bench scenarios can show three further behaviours:
- The reset values, including the default-on feature bit.
- That both layouts place enable and mode at the same positions when driven with the same bus traffic.
- That read-modify-write sequences keep the feature bit while the mode changes.

// File: rtl/ctl_reg_apb.sv
module ctl_reg_apb #(
  parameter bit          REV_B     = 1'b1,
  parameter logic [31:0] RSVD_ONES = 32'h8000_0000,
  parameter int          ADDR_W    = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              ctl_en,
  output logic [2:0]        ctl_mode,
  output logic              ctl_feat
);
  localparam logic [31:0] DEF_MASK = REV_B ? 32'h0000_001F : 32'h0000_000F;
  localparam logic [31:0] ONE_MASK = RSVD_ONES & ~DEF_MASK;

  logic        hit, wr;
  logic [31:0] rd_word;

  assign hit = (paddr == '0);
  assign wr  = psel & penable & pwrite & hit;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      ctl_en   <= 1'b0;
      ctl_mode <= 3'd0;
    end else if (wr) begin
      ctl_en   <= pwdata[0];
      ctl_mode <= pwdata[3:1];
    end

  generate
    if (REV_B) begin : g_feat
      logic feat_q;
      always_ff @(posedge pclk or negedge presetn)
        if (!presetn)  feat_q <= 1'b1;
        else if (wr)   feat_q <= pwdata[4];
      assign ctl_feat = feat_q;
    end else begin : g_legacy
      assign ctl_feat = 1'b1;
    end
  endgenerate

  assign rd_word = ({27'd0, ctl_feat, ctl_mode, ctl_en} & DEF_MASK) | ONE_MASK;
  assign prdata  = (psel && !pwrite && hit) ? rd_word : 32'd0;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  AST_RSVD_CONST: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && hit) |-> ((prdata & ~DEF_MASK) == ONE_MASK)); // R5
  AST_WRITE_MERGE: assert property (@(posedge pclk) disable iff (!presetn)
    wr |=> ((rd_word ^ ONE_MASK) == ($past(pwdata) & DEF_MASK))); // R5
  AST_EN_LOAD: assert property (@(posedge pclk) disable iff (!presetn)
    wr |=> (ctl_en == $past(pwdata[0]))); // R1
  AST_MODE_LOAD: assert property (@(posedge pclk) disable iff (!presetn)
    wr |=> (ctl_mode == $past(pwdata[3:1]))); // R2
  AST_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    !wr |=> $stable({ctl_feat, ctl_mode, ctl_en})); // R6
  AST_MISS_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !hit) |-> (prdata == 32'd0)); // R7
  AST_NO_WAIT: assert property (@(posedge pclk) disable iff (!presetn)
    (pready && !pslverr)); // R8
endmodule

// File: tb/tb_ctl_reg_apb.sv
module tb_ctl_reg_apb;
  logic pclk = 1'b0, presetn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] rd_b, rd_a;
  logic rdy_b, err_b, rdy_a, err_a;
  logic en_b, en_a, feat_b, feat_a;
  logic [2:0] mode_b, mode_a;
  int checks = 0, errors = 0;

  logic [31:0] exp_q[$];
  bit          isa_q[$];
  string       tag_q[$];

  always #2.5 pclk = ~pclk;

  ctl_reg_apb #(.REV_B(1'b1)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rd_b), .pready(rdy_b), .pslverr(err_b),
    .ctl_en(en_b), .ctl_mode(mode_b), .ctl_feat(feat_b));

  ctl_reg_apb #(.REV_B(1'b0)) dut_a (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rd_a), .pready(rdy_a), .pslverr(err_a),
    .ctl_en(en_a), .ctl_mode(mode_a), .ctl_feat(feat_a));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge pclk)
    if (psel && penable && !pwrite && exp_q.size() > 0) begin
      logic [31:0] e;
      bit a;
      string t;
      e = exp_q.pop_front();
      a = isa_q.pop_front();
      t = tag_q.pop_front();
      check(t, a ? rd_a : rd_b, e);
    end

  task automatic apb_write(input logic [7:0] addr, input logic [31:0] data);
    @(posedge pclk); #1;
    psel = 1; pwrite = 1; penable = 0; paddr = addr; pwdata = data;
    @(posedge pclk); #1;
    penable = 1;
    @(posedge pclk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [7:0] addr, input bit isa, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); isa_q.push_back(isa); tag_q.push_back(tag);
    @(posedge pclk); #1;
    psel = 1; pwrite = 0; penable = 0; paddr = addr;
    @(posedge pclk); #1;
    penable = 1;
    @(posedge pclk); #1;
    psel = 0; penable = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge pclk);
    #1 presetn = 1;
    #1;
    check("R1 reset en", {31'd0, en_b}, 0);
    check("R2 reset mode", {29'd0, mode_b}, 0);
    check("R4 reset feat", {31'd0, feat_b}, 1);
    check("R3 legacy feat", {31'd0, feat_a}, 1);
    check("R8 handshake", {28'd0, rdy_b, err_b, rdy_a, err_a}, 32'hA);
    apb_read(8'h00, 0, 32'h8000_0010, "R4 R5 reset read B");
    apb_read(8'h00, 1, 32'h8000_0000, "R3 R5 reset read A");

    apb_write(8'h00, 32'hFFFF_FFFF);
    check("R1 en set", {31'd0, en_b}, 1);
    check("R2 mode set", {29'd0, mode_b}, 7);
    apb_read(8'h00, 0, 32'h8000_001F, "R5 all-ones write B");
    apb_read(8'h00, 1, 32'h8000_000F, "R3 R5 all-ones write A");
    check("R3 feat A fixed", {31'd0, feat_a}, 1);

    apb_write(8'h00, 32'h0000_0000);
    check("R4 feat cleared", {31'd0, feat_b}, 0);
    apb_read(8'h00, 0, 32'h8000_0000, "R5 zero write keeps bit31");

    apb_write(8'h00, 32'h7FFF_FFEA);
    check("R9 en same A/B", {31'd0, en_a}, {31'd0, en_b});
    check("R9 mode same A/B", {29'd0, mode_a}, {29'd0, mode_b});
    check("R2 mode 5", {29'd0, mode_b}, 5);
    apb_read(8'h00, 0, 32'h8000_000A, "R5 R9 pattern B");
    apb_read(8'h00, 1, 32'h8000_000A, "R9 pattern A");

    apb_write(8'h00, 32'h8000_001A);
    w = 32'h8000_001A;
    w = (w & ~32'h0000_000E) | (3'd2 << 1);
    apb_write(8'h00, w);
    check("R4 feat kept by rmw", {31'd0, feat_b}, 1);
    check("R2 mode rmw", {29'd0, mode_b}, 2);

    apb_write(8'h04, 32'h0000_0001);
    check("R6 other offset ignored", {31'd0, en_b}, 0);
    apb_read(8'h04, 0, 32'h0, "R7 other offset reads zero");

    @(posedge pclk); #1;
    psel = 1; pwrite = 1; penable = 0; paddr = 8'h00; pwdata = 32'h0000_0001;
    @(posedge pclk); #1;
    psel = 0; pwrite = 0;
    #1;
    check("R6 setup only ignored", {31'd0, en_b}, 0);
    apb_read(8'h00, 0, 32'h8000_0014, "R6 R5 word unchanged");

    repeat (3) @(posedge pclk);
    check("R5 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule